// File: doc/BRIEF.md
# USB Control Endpoint Handshake Controller

This block runs the device side of a USB control transfer on endpoint zero. It works at the level of tokens and handshakes. Upstream logic hands it decoded tokens, the bytes of each received data packet, and an end-of-packet strobe that carries the data PID and a CRC-good flag. The block keeps the eight setup bytes in a local buffer that firmware can read. It raises two sticky interrupt requests and picks the answer to each token or setup packet: ACK, NAK, STALL or silence.

Firmware works through a small write port. Address 0 holds the control bits: bit 0 is a write-one-to-clear hold bit that keeps the status stage waiting, and bit 1 sets the stall bit. Address 1 clears interrupt requests with write-one-to-clear: bit 0 is the setup-token request and bit 1 is the setup-data request. Any write to address 2 loads a data-stage byte count, and that write arms the data stage.

The response to a token or to a setup packet is registered. It appears on `resp_valid`/`resp_code` one cycle after the event. Codes: 1 = ACK, 2 = NAK, 3 = STALL. For tokens on `tok_pid`: 1 = SETUP, 2 = IN, 3 = OUT. For a data-stage token, ACK means the endpoint is armed and serves the packet.

Top module: `usb_ep0_hs`

## Requirements
- R1: A SETUP token sets `irq_setup_tok` on the following cycle. The token itself gets no response. The request stays set until it is cleared.
- R2: A setup packet that is DATA0, has a good CRC and holds exactly 8 bytes, arriving after a SETUP token, gets ACK. It also sets `irq_setup_data` and `hold`. Its bytes can be read in order at `setup_byte` using index 0..7.
- R3: A setup packet that has a bad CRC, carries DATA1 or holds the wrong byte count gets no response and sets no data request. The block keeps waiting for a retried packet.
- R4: A SETUP token is never stalled. It clears the stall bit, and the setup packet that follows gets ACK even if firmware had set stall beforehand.
- R5: Bit 7 of setup byte 0 gives the data-stage direction (1 = IN). Data-stage tokens get NAK until firmware writes address 2. After that write they get ACK.
- R6: When setup bytes 6 and 7 are both zero, there is no data stage. The status stage is then an IN token, and an OUT token gets no response.
- R7: The status token is the direction opposite to the data stage. It gets NAK while `hold` is set. After firmware writes 1 to address 0 bit 0, it gets ACK and the transfer ends, so later IN/OUT tokens get no response.
- R8: STALL is sent for a data-stage or status-stage token only when both `stall` and `hold` are set. With `stall` set and `hold` clear, the normal answer is given.
- R9: A SETUP token in the middle of a transfer aborts that transfer, clears `stall` and the armed state, and waits for a new setup packet.
- R10: Writing 1 to address 1 bit 0 clears `irq_setup_tok`, and writing 1 to bit 1 clears `irq_setup_data`. Writing 0 to a bit leaves that request as it is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tok_valid | input | 1 | Decoded token strobe |
| tok_pid | input | 2 | Token kind: 1 SETUP, 2 IN, 3 OUT |
| rx_byte_valid | input | 1 | Received data byte strobe |
| rx_byte | input | 8 | Received data byte |
| rx_done | input | 1 | End of received data packet |
| rx_data1 | input | 1 | Packet carried DATA1 (0 = DATA0) |
| rx_crc_ok | input | 1 | Packet CRC was good |
| fw_we | input | 1 | Firmware write strobe |
| fw_addr | input | 2 | Firmware write address |
| fw_wdata | input | 8 | Firmware write data |
| setup_idx | input | 3 | Setup buffer read index |
| setup_byte | output | 8 | Setup buffer byte at `setup_idx` |
| resp_valid | output | 1 | Response strobe |
| resp_code | output | 2 | 1 ACK, 2 NAK, 3 STALL |
| irq_setup_tok | output | 1 | Setup-token interrupt request |
| irq_setup_data | output | 1 | Setup-data-available interrupt request |
| hold | output | 1 | Status-stage hold bit |
| stall | output | 1 | Stall bit |

## Verification
The assertions assume that a token, a packet byte and an end-of-packet strobe never arrive in the same cycle. They also assume that `rx_done` comes in a cycle after the last byte of its packet. Without these two conditions, a CRC-failed packet could not be told apart from a token answered in the same cycle. The bench keeps each bus event in its own cycle and always leaves at least one idle cycle between events. Firmware writes are applied only between events, so the assertions' idea of what happened in the previous cycle stays clear.

// File: rtl/usb_ep0_hs.sv
module usb_ep0_hs (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tok_valid,
  input  logic [1:0] tok_pid,
  input  logic       rx_byte_valid,
  input  logic [7:0] rx_byte,
  input  logic       rx_done,
  input  logic       rx_data1,
  input  logic       rx_crc_ok,
  input  logic       fw_we,
  input  logic [1:0] fw_addr,
  input  logic [7:0] fw_wdata,
  input  logic [2:0] setup_idx,
  output logic [7:0] setup_byte,
  output logic       resp_valid,
  output logic [1:0] resp_code,
  output logic       irq_setup_tok,
  output logic       irq_setup_data,
  output logic       hold,
  output logic       stall
);
  localparam logic [1:0] PID_SETUP = 2'd1, PID_IN = 2'd2, PID_OUT = 2'd3;
  localparam logic [1:0] R_ACK = 2'd1, R_NAK = 2'd2, R_STALL = 2'd3;

  typedef enum logic [1:0] {S_IDLE, S_SETUP, S_DATA, S_STATUS} stage_t;
  stage_t stage;

  logic [7:0] sbuf [8];
  logic [3:0] bcnt;
  logic       dir_in, has_data, armed;

  assign setup_byte = sbuf[setup_idx];

  wire setup_tok = tok_valid && tok_pid == PID_SETUP;
  wire setup_ok  = stage == S_SETUP && rx_done && rx_crc_ok && !rx_data1 && bcnt == 4'd8;
  wire [1:0] data_pid = dir_in ? PID_IN : PID_OUT;
  wire [1:0] stat_pid = (has_data && dir_in) ? PID_OUT : PID_IN;
  wire data_tok  = tok_valid && stage == S_DATA && tok_pid == data_pid;
  wire stat_tok  = tok_valid && (stage == S_DATA || stage == S_STATUS) && tok_pid == stat_pid;
  wire stall_now = stall && hold;
  wire fw_ctl    = fw_we && fw_addr == 2'd0;
  wire fw_irq    = fw_we && fw_addr == 2'd1;
  wire fw_arm    = fw_we && fw_addr == 2'd2;
  wire new_len   = (sbuf[6] | sbuf[7]) != 8'd0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage <= S_IDLE;
      bcnt <= '0;
      dir_in <= 1'b0;
      has_data <= 1'b0;
      armed <= 1'b0;
      hold <= 1'b0;
      stall <= 1'b0;
      irq_setup_tok <= 1'b0;
      irq_setup_data <= 1'b0;
      resp_valid <= 1'b0;
      resp_code <= '0;
    end else begin
      resp_valid <= 1'b0;

      if (fw_irq && fw_wdata[0]) irq_setup_tok <= 1'b0;
      if (fw_irq && fw_wdata[1]) irq_setup_data <= 1'b0;
      if (fw_ctl && fw_wdata[0]) hold <= 1'b0;
      if (fw_ctl && fw_wdata[1]) stall <= 1'b1;
      if (fw_arm) armed <= 1'b1;

      if (setup_tok) begin
        stage <= S_SETUP;
        bcnt <= '0;
        stall <= 1'b0;
        armed <= 1'b0;
        irq_setup_tok <= 1'b1;
      end else if (stage == S_SETUP && rx_byte_valid) begin
        if (bcnt < 4'd8) sbuf[bcnt[2:0]] <= rx_byte;
        if (bcnt != 4'd15) bcnt <= bcnt + 4'd1;
      end else if (stage == S_SETUP && rx_done) begin
        bcnt <= '0;
        if (setup_ok) begin
          resp_valid <= 1'b1;
          resp_code <= R_ACK;
          irq_setup_data <= 1'b1;
          hold <= 1'b1;
          armed <= 1'b0;
          dir_in <= sbuf[0][7];
          has_data <= new_len;
          stage <= new_len ? S_DATA : S_STATUS;
        end
      end else if (data_tok) begin
        resp_valid <= 1'b1;
        resp_code <= stall_now ? R_STALL : (armed ? R_ACK : R_NAK);
      end else if (stat_tok) begin
        resp_valid <= 1'b1;
        resp_code <= stall_now ? R_STALL : (hold ? R_NAK : R_ACK);
        stage <= (!stall_now && !hold) ? S_IDLE : S_STATUS;
      end
    end
  end
endmodule

module usb_ep0_hs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tok_valid,
  input logic [1:0] tok_pid,
  input logic       rx_done,
  input logic       rx_crc_ok,
  input logic       fw_we,
  input logic [1:0] fw_addr,
  input logic [7:0] fw_wdata,
  input logic       resp_valid,
  input logic [1:0] resp_code,
  input logic       irq_setup_tok,
  input logic       irq_setup_data,
  input logic       hold,
  input logic       stall
);
  assert_setup_irq_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_valid && tok_pid == 2'd1) |=> irq_setup_tok);

  assert_setup_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_valid && tok_pid == 2'd1) |=> !resp_valid && !stall);

  assert_data_sets_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_setup_data) |-> hold);

  assert_bad_crc_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && !rx_crc_ok && !tok_valid) |=> !resp_valid);

  assert_stall_needs_both_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_code == 2'd3) |-> ($past(stall) && $past(hold)));

  assert_irq_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_setup_tok && !(fw_we && fw_addr == 2'd1 && fw_wdata[0])) |=> irq_setup_tok);
endmodule

bind usb_ep0_hs usb_ep0_hs_chk u_chk (.*);

// File: tb/sim_usb_ep0_hs.sv
module sim_usb_ep0_hs;
  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] SETUP = 2'd1, IN = 2'd2, OUT = 2'd3;
  localparam logic [1:0] NONE = 2'd0, ACK = 2'd1, NAK = 2'd2, STALL = 2'd3;

  logic clk = 0, rst_n = 0;
  logic tok_valid = 0, rx_byte_valid = 0, rx_done = 0, rx_data1 = 0, rx_crc_ok = 0, fw_we = 0;
  logic [1:0] tok_pid = 0, fw_addr = 0, resp_code;
  logic [7:0] rx_byte = 0, fw_wdata = 0, setup_byte;
  logic [2:0] setup_idx = 0;
  logic resp_valid, irq_setup_tok, irq_setup_data, hold, stall;

  int n_run = 0, n_fail = 0;
  bit finished = 0;
  logic [1:0] exp_q [$];
  string tag_q [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  usb_ep0_hs u0 (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && resp_valid) begin
    if (exp_q.size() == 0) chk(0, "unexpected response", int'(resp_code), 0);
    else begin
      automatic logic [1:0] e = exp_q.pop_front();
      automatic string t = tag_q.pop_front();
      chk(resp_code == e, t, int'(resp_code), int'(e));
    end
  end

  task automatic expect_resp(input logic [1:0] e, input string tag);
    if (e != NONE) begin exp_q.push_back(e); tag_q.push_back(tag); end
  endtask

  task automatic after(input logic [1:0] e, input string tag);
    if (e == NONE) chk(!resp_valid, tag, int'(resp_valid), 0);
    @(negedge clk);
  endtask

  task automatic tok(input logic [1:0] pid, input logic [1:0] e, input string tag);
    expect_resp(e, tag);
    tok_valid = 1; tok_pid = pid;
    @(negedge clk);
    tok_valid = 0;
    after(e, tag);
  endtask

  task automatic pkt(input logic [63:0] b, input int n, input bit crc, input bit d1,
                     input logic [1:0] e, input string tag);
    for (int i = 0; i < n; i++) begin
      rx_byte_valid = 1; rx_byte = b[i*8 +: 8];
      @(negedge clk);
      rx_byte_valid = 0;
      @(negedge clk);
    end
    expect_resp(e, tag);
    rx_done = 1; rx_crc_ok = crc; rx_data1 = d1;
    @(negedge clk);
    rx_done = 0;
    after(e, tag);
  endtask

  task automatic fw(input logic [1:0] a, input logic [7:0] d);
    fw_we = 1; fw_addr = a; fw_wdata = d;
    @(negedge clk);
    fw_we = 0;
    @(negedge clk);
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    if (!finished) begin
      n_fail++; n_run++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!irq_setup_tok && !irq_setup_data && !hold && !stall && !resp_valid,
        "reset state", {irq_setup_tok, irq_setup_data, hold, stall}, 0);

    tok(SETUP, NONE, "R1 setup token silent");
    chk(irq_setup_tok, "R1 setup irq", irq_setup_tok, 1);
    pkt(64'h0012_0000_0100_0680, 8, 0, 0, NONE, "R3 bad crc");
    chk(!irq_setup_data, "R3 no data irq", irq_setup_data, 0);
    pkt(64'h0012_0000_0100_0680, 8, 1, 1, NONE, "R3 data1 packet");
    pkt(64'h0000_0100_0680, 6, 1, 0, NONE, "R3 short packet");
    chk(irq_setup_data == 0, "R3 still no data irq", irq_setup_data, 0);
    pkt(64'h0012_0000_0100_0680, 8, 1, 0, ACK, "R2 good setup");
    chk(irq_setup_data && hold, "R2 irq and hold", {irq_setup_data, hold}, 3);
    for (int i = 0; i < 8; i++) begin
      automatic logic [63:0] ref_b = 64'h0012_0000_0100_0680;
      setup_idx = 3'(i);
      #1 chk(setup_byte == ref_b[i*8 +: 8], "R2 setup buffer", setup_byte, ref_b[i*8 +: 8]);
    end
    @(negedge clk);

    tok(IN, NAK, "R5 data unarmed");
    fw(2'd2, 8'h12);
    tok(IN, ACK, "R5 data armed");
    tok(OUT, NAK, "R7 status held");
    fw(2'd0, 8'h01);
    chk(!hold, "R7 hold cleared", hold, 0);
    tok(OUT, ACK, "R7 status ack");
    tok(IN, NONE, "R7 idle after done");

    fw(2'd1, 8'h01);
    chk(!irq_setup_tok && irq_setup_data, "R10 clear tok only", {irq_setup_tok, irq_setup_data}, 1);
    fw(2'd1, 8'h00);
    chk(irq_setup_data, "R10 zero write no effect", irq_setup_data, 1);
    fw(2'd1, 8'h02);
    chk(!irq_setup_data, "R10 clear data", irq_setup_data, 0);

    fw(2'd0, 8'h02);
    chk(stall, "R4 stall preset", stall, 1);
    tok(SETUP, NONE, "R4 setup not stalled");
    chk(!stall, "R4 stall cleared", stall, 0);
    pkt(64'h0000_0000_0001_0900, 8, 1, 0, ACK, "R4 setup accepted");
    tok(OUT, NONE, "R6 no data stage out");
    tok(IN, NAK, "R6 status in held");
    fw(2'd0, 8'h02);
    tok(IN, STALL, "R8 stall with hold");
    fw(2'd0, 8'h01);
    chk(stall && !hold, "R8 stall only", {stall, hold}, 2);
    tok(IN, ACK, "R8 stall alone ignored");

    tok(SETUP, NONE, "R9 setup");
    pkt(64'h0004_0000_0000_0121, 8, 1, 0, ACK, "R9 setup out dir");
    tok(OUT, NAK, "R9 data out unarmed");
    fw(2'd2, 8'h04);
    fw(2'd0, 8'h02);
    tok(OUT, STALL, "R9 data out stalled");
    tok(SETUP, NONE, "R9 abort setup");
    chk(!stall, "R9 stall cleared", stall, 0);
    tok(IN, NONE, "R9 awaiting setup packet");
    pkt(64'h0004_0000_0000_0121, 8, 1, 0, ACK, "R9 new setup");
    tok(OUT, NAK, "R9 armed cleared");

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule